// File: doc/BRIEF.md
# I2C Target Address Matcher

This block sits behind a bit-level I2C receiver and decides, for every START or repeated START, whether the local target should claim the transfer. The receiver hands it a START strobe, a STOP strobe and each completed byte. The block compares the address bytes with a 10-bit own-address value under either 7-bit or 10-bit rules. It returns a one-cycle acknowledge pulse for every address byte it accepts, the transfer direction that goes with that pulse, and a flag that stays high while the target is addressed.

The two addressing modes exclude each other. In 7-bit mode, a first byte carrying the 10-bit header pattern is never claimed. In 10-bit mode, a plain 7-bit address is never claimed, even when it equals the low bits of the own address. A 10-bit read is reached the usual way: the write header and the low address byte, then a repeated START with the header and the read bit set. That read is accepted only while the target is still addressed. A disable control silences the block completely. The mode, the own address and the disable control are captured only while the bus is idle.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset `matchAck`, `readDir` and `addressed` are all 0.
- R2: In 7-bit mode (`longMode`=0), a first byte after START whose bits 7:1 equal `ownAddr[6:0]` is accepted. Bits 9:7 of `ownAddr` play no part. `matchAck` is high for exactly the one cycle after the byte strobe. `readDir` takes byte bit 0 (1 = read), and `addressed` goes to 1.
- R3: In 7-bit mode, a first byte whose bits 7:3 are 11110 is never acknowledged, even when its bits 7:1 equal `ownAddr[6:0]`.
- R4: In 10-bit mode (`longMode`=1), the first byte is 11110, then `ownAddr[9:8]` in bits 2:1, then 0 in bit 0. The second byte equals `ownAddr[7:0]`. Each of the two bytes is acknowledged. After the second byte `addressed` is 1 and `readDir` is 0.
- R5: In 10-bit mode, a header whose bits 2:1 differ from `ownAddr[9:8]` gets no acknowledge, and neither does the byte after it. If the header matches but the second byte differs, only the header is acknowledged and `addressed` stays 0.
- R6: In 10-bit mode, a first byte without the 11110 prefix gets no acknowledge.
- R7: In 10-bit mode, a header with bit 0 = 1 is acknowledged with `readDir`=1 only if `addressed` is 1 when the byte arrives. Otherwise it is ignored.
- R8: A STOP clears `addressed` in the next cycle. So does a first byte after a START that is not accepted.
- R9: While the captured `targetOff` is 1, no byte is acknowledged in either mode.
- R10: `ownAddr`, `longMode` and `targetOff` are captured only while the bus is idle, meaning from reset or a STOP up to and including the cycle of the next START. Changes made between that START and the following STOP have no effect.
- R11: Bytes received after an accepted address (the data phase) are never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSeen | input | 1 | One-cycle strobe: START or repeated START seen |
| stopSeen | input | 1 | One-cycle strobe: STOP seen |
| byteValid | input | 1 | One-cycle strobe: `byteData` holds a received byte |
| byteData | input | 8 | Received byte, MSB first on the wire |
| ownAddr | input | 10 | Own target address |
| longMode | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| targetOff | input | 1 | 1 = all target responses disabled |
| matchAck | output | 1 | One-cycle pulse: address byte accepted, ACK it |
| readDir | output | 1 | Direction of the last accepted address, 1 = read |
| addressed | output | 1 | Target currently addressed |

## Verification
The bench probes the mode boundary from both sides. A 7-bit mode target faced with a header-shaped byte that equals its own low bits must stay silent, and a 10-bit mode target must ignore the 7-bit form of its own address; a design that compared without checking the prefix would acknowledge both. It splits 10-bit failures between the header and the low byte, so that a design acknowledging the second byte after a bad header, or keeping `addressed` after a bad low byte, is caught. A read header with no prior write addressing shows whether the addressed-state condition on re-addressing is enforced. Finally, the configuration is changed right after a START: a design that did not hold its captured copy would answer with the new address in the middle of the transfer.

// File: rtl/i2c_addr_match_pkg.sv
package i2c_addr_match_pkg;
  localparam int ADDR_W  = 10;
  localparam int BYTE_W  = 8;
  localparam int SHORT_W = 7;
  localparam int HI_W    = ADDR_W - BYTE_W;
  localparam int PFX_W   = BYTE_W - HI_W - 1;
  localparam logic [PFX_W-1:0] LONG_PFX = 5'b11110;

  // comparison results from the datapath
  typedef struct packed {
    logic isLongHdr;
    logic hiHit;
    logic shortHit;
    logic lowHit;
    logic rwBit;
    logic longMode;
    logic off;
  } cmp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic ack;
    logic dirRead;
    logic setAddr;
    logic clrAddr;
  } strb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_DATA,
    ST_SKIP
  } st_t;
endpackage

// File: rtl/i2c_addr_match_dp.sv
module i2c_addr_match_dp
  import i2c_addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              longModeIn,
  input  logic              offIn,
  input  strb_t             strb,
  output cmp_t              cmp,
  output logic              matchAck,
  output logic              readDir,
  output logic              addressed
);
  logic [ADDR_W-1:0] ownQ;
  logic              longQ;
  logic              offQ;

  // configuration shadow, reloaded only while the bus is idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownQ  <= '0;
      longQ <= 1'b1;
      offQ  <= 1'b0;
    end else if (strb.loadCfg) begin
      ownQ  <= ownAddr;
      longQ <= longModeIn;
      offQ  <= offIn;
    end
  end

  always_comb begin
    cmp.isLongHdr = (byteData[BYTE_W-1 -: PFX_W] == LONG_PFX);
    cmp.hiHit     = (byteData[HI_W:1] == ownQ[ADDR_W-1:BYTE_W]);
    cmp.shortHit  = (byteData[BYTE_W-1:1] == ownQ[SHORT_W-1:0]);
    cmp.lowHit    = (byteData == ownQ[BYTE_W-1:0]);
    cmp.rwBit     = byteData[0];
    cmp.longMode  = longQ;
    cmp.off       = offQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchAck  <= 1'b0;
      readDir   <= 1'b0;
      addressed <= 1'b0;
    end else begin
      matchAck <= strb.ack;
      if (strb.ack) readDir <= strb.dirRead;
      if (strb.clrAddr)      addressed <= 1'b0;
      else if (strb.setAddr) addressed <= 1'b1;
    end
  end

  assert_ack_follows_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    matchAck |-> $past(byteValid));
  assert_dir_only_on_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    !matchAck |-> $stable(readDir));
  assert_no_ack_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    matchAck |-> !$past(offQ));
  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.loadCfg) |-> ($stable(ownQ) && $stable(longQ) && $stable(offQ)));
endmodule

// File: rtl/i2c_addr_match_ctrl.sv
module i2c_addr_match_ctrl
  import i2c_addr_match_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startSeen,
  input  logic  stopSeen,
  input  logic  byteValid,
  input  cmp_t  cmp,
  input  logic  addressed,
  output strb_t strb
);
  st_t st, stNxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNxt;
  end

  always_comb begin
    strb         = '0;
    stNxt        = st;
    strb.loadCfg = (st == ST_IDLE);
    if (stopSeen) begin
      stNxt        = ST_IDLE;
      strb.clrAddr = 1'b1;
    end else if (startSeen) begin
      stNxt = ST_FIRST;
    end else if (byteValid) begin
      case (st)
        ST_FIRST: begin
          if (cmp.off) begin
            strb.clrAddr = 1'b1;
            stNxt        = ST_SKIP;
          end else if (!cmp.longMode) begin
            if (!cmp.isLongHdr && cmp.shortHit) begin
              strb.ack     = 1'b1;
              strb.dirRead = cmp.rwBit;
              strb.setAddr = 1'b1;
              stNxt        = ST_DATA;
            end else begin
              strb.clrAddr = 1'b1;
              stNxt        = ST_SKIP;
            end
          end else if (cmp.isLongHdr && cmp.hiHit && !cmp.rwBit) begin
            strb.ack     = 1'b1;
            strb.clrAddr = 1'b1;
            stNxt        = ST_SECOND;
          end else if (cmp.isLongHdr && cmp.hiHit && addressed) begin
            strb.ack     = 1'b1;
            strb.dirRead = 1'b1;
            strb.setAddr = 1'b1;
            stNxt        = ST_DATA;
          end else begin
            strb.clrAddr = 1'b1;
            stNxt        = ST_SKIP;
          end
        end
        ST_SECOND: begin
          if (cmp.lowHit) begin
            strb.ack     = 1'b1;
            strb.setAddr = 1'b1;
            stNxt        = ST_DATA;
          end else begin
            strb.clrAddr = 1'b1;
            stNxt        = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assert_second_only_long_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SECOND) |-> cmp.longMode);
  assert_stop_to_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (st == ST_IDLE));
  assert_no_ack_in_data_R11: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_DATA && !startSeen) |=> !strb.ack);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              longMode,
  input  logic              targetOff,
  output logic              matchAck,
  output logic              readDir,
  output logic              addressed
);
  strb_t strb;
  cmp_t  cmp;

  i2c_addr_match_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .byteValid (byteValid),
    .cmp       (cmp),
    .addressed (addressed),
    .strb      (strb)
  );

  i2c_addr_match_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .ownAddr    (ownAddr),
    .longModeIn (longMode),
    .offIn      (targetOff),
    .strb       (strb),
    .cmp        (cmp),
    .matchAck   (matchAck),
    .readDir    (readDir),
    .addressed  (addressed)
  );

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !addressed);
endmodule

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startSeen = 1'b0, stopSeen = 1'b0, byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic [9:0] ownAddr = '0;
  logic       longMode = 1'b0, targetOff = 1'b0;
  logic       matchAck, readDir, addressed;

  int nRun = 0, nFail = 0, cyc = 0;
  logic gotAck, gotDir;

  always #2.5 clk = ~clk;

  i2c_addr_match u_dut (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .byteValid(byteValid), .byteData(byteData), .ownAddr(ownAddr),
    .longMode(longMode), .targetOff(targetOff),
    .matchAck(matchAck), .readDir(readDir), .addressed(addressed)
  );

  typedef struct packed {
    logic       ten;
    logic       off;
    logic [9:0] own;
    logic [7:0] b1;
    logic       two;
    logic [7:0] b2;
    logic       a1;
    logic       a2;
    logic       dir;
    logic       adr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 10'h3A5, 8'h4B, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2}, // R2 read, upper bits ignored
    '{1'b0, 1'b0, 10'h025, 8'h4C, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 mismatch
    '{1'b0, 1'b0, 10'h078, 8'hF0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 header in 7-bit mode
    '{1'b1, 1'b0, 10'h2C7, 8'hF4, 1'b1, 8'hC7, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4}, // R4 full match
    '{1'b1, 1'b0, 10'h2C7, 8'hF6, 1'b1, 8'hC7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 high bits differ
    '{1'b1, 1'b0, 10'h2C7, 8'hF4, 1'b1, 8'hC6, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 low byte differs
    '{1'b1, 1'b0, 10'h025, 8'h4A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 short form in 10-bit mode
    '{1'b0, 1'b1, 10'h025, 8'h4A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 off, 7-bit
    '{1'b1, 1'b1, 10'h2C7, 8'hF4, 1'b1, 8'hC7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 off, 10-bit
    '{1'b1, 1'b0, 10'h2C7, 8'hF5, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7}  // R7 read without addressing
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doStart();
    @(negedge clk) startSeen = 1'b1;
    @(negedge clk) startSeen = 1'b0;
  endtask

  task automatic doStop();
    @(negedge clk) stopSeen = 1'b1;
    @(negedge clk) stopSeen = 1'b0;
  endtask

  // one byte strobe; ack sampled one cycle later, pulse end checked after that
  task automatic sendByte(input logic [7:0] b, input string tag);
    @(negedge clk) begin byteData = b; byteValid = 1'b1; end
    @(negedge clk) begin byteValid = 1'b0; gotAck = matchAck; gotDir = readDir; end
    @(negedge clk) chk({tag, " R2 pulse width"}, {31'b0, matchAck}, 32'd0);
  endtask

  task automatic setCfg(input logic ten, input logic off, input logic [9:0] own);
    @(negedge clk) begin longMode = ten; targetOff = off; ownAddr = own; end
  endtask

  initial begin
    forever begin
      @(posedge clk) cyc++;
      if (cyc > 50000) begin
        nRun++; nFail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 matchAck", {31'b0, matchAck}, 32'd0);
    chk("R1 readDir",  {31'b0, readDir},  32'd0);
    chk("R1 addressed",{31'b0, addressed},32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
      doStop();
      setCfg(VECS[i].ten, VECS[i].off, VECS[i].own);
      doStart();
      sendByte(VECS[i].b1, tg);
      chk({tg, " ack1"}, {31'b0, gotAck}, {31'b0, VECS[i].a1});
      if (VECS[i].a1) chk({tg, " dir1"}, {31'b0, gotDir}, 32'd0 | (VECS[i].two ? 1'b0 : VECS[i].dir));
      if (VECS[i].two) begin
        sendByte(VECS[i].b2, tg);
        chk({tg, " ack2"}, {31'b0, gotAck}, {31'b0, VECS[i].a2});
      end
      if (VECS[i].a1 || VECS[i].a2) chk({tg, " dir"}, {31'b0, readDir}, {31'b0, VECS[i].dir});
      chk({tg, " addressed"}, {31'b0, addressed}, {31'b0, VECS[i].adr});
    end

    // R7 and R11: 10-bit write addressing, data byte, then read re-addressing
    doStop();
    setCfg(1'b1, 1'b0, 10'h2C7);
    doStart();
    sendByte(8'hF4, "R4 hdr");
    sendByte(8'hC7, "R4 low");
    chk("R4 addressed", {31'b0, addressed}, 32'd1);
    sendByte(8'hF4, "R11 data");
    chk("R11 data byte no ack", {31'b0, gotAck}, 32'd0);
    doStart();
    sendByte(8'hF5, "R7 read");
    chk("R7 read ack", {31'b0, gotAck}, 32'd1);
    chk("R7 read dir", {31'b0, readDir}, 32'd1);
    chk("R7 addressed", {31'b0, addressed}, 32'd1);

    // R8: repeated START with a foreign address drops the addressed state
    doStart();
    sendByte(8'h12, "R8 foreign");
    chk("R8 foreign no ack", {31'b0, gotAck}, 32'd0);
    chk("R8 cleared by unmatched start", {31'b0, addressed}, 32'd0);

    // R8: STOP clears the addressed state
    doStop();
    setCfg(1'b0, 1'b0, 10'h025);
    doStart();
    sendByte(8'h4A, "R8 addr");
    chk("R8 7-bit write ack", {31'b0, gotAck}, 32'd1);
    chk("R8 7-bit write dir", {31'b0, readDir}, 32'd0);
    doStop();
    chk("R8 cleared by stop", {31'b0, addressed}, 32'd0);

    // R10: configuration changed right after START is not used
    setCfg(1'b0, 1'b0, 10'h025);
    doStart();
    setCfg(1'b1, 1'b1, 10'h030);
    sendByte(8'h4A, "R10 held");
    chk("R10 old config still used", {31'b0, gotAck}, 32'd1);
    doStart();
    sendByte(8'h4A, "R10 rstart");
    chk("R10 repeated start keeps config", {31'b0, gotAck}, 32'd1);
    doStop();
    setCfg(1'b1, 1'b0, 10'h030);
    doStart();
    sendByte(8'h4A, "R10 new mode");
    chk("R10 new mode ignores short form", {31'b0, gotAck}, 32'd0);
    doStop();
    doStart();
    sendByte(8'hF0, "R10 new hdr");
    chk("R10 new address header ack", {31'b0, gotAck}, 32'd1);
    sendByte(8'h30, "R10 new low");
    chk("R10 new address low ack", {31'b0, gotAck}, 32'd1);
    chk("R10 new address addressed", {31'b0, addressed}, 32'd1);
    doStop();

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule